// File: doc/BRIEF.md
# Accumulator CPU with a single shared bus

This block is a very small stored-program computer with an 8-bit word. Program bytes and data bytes both live in one 16 x 8 memory. Every transfer between the program counter, the address register, the memory, the instruction register, the accumulator, the operand register, the adder/subtractor and the output register goes over one internal bus. Because only one source can drive that bus in a step, an instruction byte and a data byte are never read together.

A six-step ring sequencer runs each instruction. The first three steps fetch the instruction: the counter value goes into the address register, the counter advances, and the addressed byte is loaded into the instruction register. The last three steps execute it. An instruction byte carries the operation code in bits 7:4 and a direct memory address in bits 3:0.

A test harness loads the memory through a write port while clear is held, then releases clear. The program then runs until a stop instruction raises the halted flag. The final result is read from the output register.

Top module: `acc_cpu`

## Requirements
- R1: While the load enable is high, the load data byte is written into memory at the load address on the rising clock edge, and a program later reads it back.
- R2: An instruction byte holds the operation code in bits 7:4 and the operand address in bits 3:0. The codes are: load 0x0, add 0x1, subtract 0x2, show 0x3, stop 0xF.
- R3: Each instruction takes exactly six clock cycles, starting at the edge that follows the release of clear. A program whose stop instruction is the k-th instruction (counting from 0) raises the halted flag at edge 6k+4.
- R4: Load copies the memory byte at the operand address into the accumulator.
- R5: Add replaces the accumulator with (A + M) mod 256, where M is the memory byte at the operand address.
- R6: Subtract replaces the accumulator with (A - M) mod 256 in two's complement. For example, 0x01 - 0x03 gives 0xFE.
- R7: The output register changes only in the fourth step of a show instruction, when it takes the accumulator value. At all other times it holds its value.
- R8: In the fourth step of a stop instruction the halted flag goes high. After that, the flag, the program counter and the output register stay frozen until clear.
- R9: Codes other than the five defined ones leave the accumulator and the output unchanged and take six cycles, like any other instruction.
- R10: A clear held over a rising edge sets the output register to 0 and the halted flag to 0. Execution then restarts at address 0 and does not depend on any state left from before the clear.
- R11: At most one source drives the internal bus in any step.
- R12: The program "load 9, add A, add B, subtract C, show, stop", with data 01, 04, 02, 03 at addresses 9 to C, leaves 0x04 in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear, active high |
| ld_we | input | 1 | Memory preload write enable |
| ld_addr | input | 4 | Memory preload address |
| ld_data | input | 8 | Memory preload data |
| out_reg | output | 8 | Output register that drives the display |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bench sweeps operand pairs through add and subtract programs. This catches a design that drops the modulo-256 wrap or gets the subtract direction wrong, since either one gives results that differ from the arithmetic model, and underflow such as 0x01 - 0x03 is checked directly. It counts the edges to the halted flag and samples the output register one edge before and one edge after the show step. A sequencer with a missing or extra step, or an output register loaded at the wrong time, fails those checks. It also places undefined codes between real instructions and clears in the middle of a run, so that a design which decodes stray codes as operations, or keeps state across a clear, produces a wrong final value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 4;
  localparam int OP_W   = WORD_W - ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NSTEPS = 6;

  // step indices of the ring sequencer
  localparam int ST_ADDR = 0;
  localparam int ST_INC  = 1;
  localparam int ST_IR   = 2;
  localparam int ST_X1   = 3;
  localparam int ST_X2   = 4;
  localparam int ST_X3   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_SHOW = 4'h3,
    OP_STOP = 4'hF
  } opcode_e;

  typedef struct packed {
    logic pc_inc;
    logic pc_drv;
    logic mar_ld;
    logic mem_drv;
    logic ir_ld;
    logic ir_drv;
    logic a_ld;
    logic a_drv;
    logic sub_sel;
    logic alu_drv;
    logic b_ld;
    logic out_ld;
    logic halt_req;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

  function automatic logic [WORD_W-1:0] alu_calc(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input logic sub);
    return sub ? (a - b) : (a + b);
  endfunction
endpackage

// File: rtl/acc_ring.sv
module acc_ring
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              hold,
  output logic [NSTEPS-1:0] step
);
  always_ff @(posedge clk) begin
    if (clr)        step <= NSTEPS'(1);
    else if (!hold) step <= {step[NSTEPS-2:0], step[NSTEPS-1]};
  end

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (clr)
    $countones(step) == 1); // R3
endmodule

// File: rtl/acc_mem.sv
module acc_mem
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic [NSTEPS-1:0] step,
  input  logic [OP_W-1:0]   opc,
  input  logic              halted,
  output ctrl_t             c
);
  always_comb begin
    c = CTRL_IDLE;
    if (!halted) begin
      if (step[ST_ADDR]) begin
        c.pc_drv = 1'b1;
        c.mar_ld = 1'b1;
      end
      if (step[ST_INC]) c.pc_inc = 1'b1;
      if (step[ST_IR]) begin
        c.mem_drv = 1'b1;
        c.ir_ld   = 1'b1;
      end
      if (step[ST_X1]) begin
        case (opc)
          OP_LOAD, OP_ADD, OP_SUB: begin
            c.ir_drv = 1'b1;
            c.mar_ld = 1'b1;
          end
          OP_SHOW: begin
            c.a_drv  = 1'b1;
            c.out_ld = 1'b1;
          end
          OP_STOP: c.halt_req = 1'b1;
          default: c = CTRL_IDLE;
        endcase
      end
      if (step[ST_X2]) begin
        case (opc)
          OP_LOAD: begin
            c.mem_drv = 1'b1;
            c.a_ld    = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            c.mem_drv = 1'b1;
            c.b_ld    = 1'b1;
          end
          default: c = CTRL_IDLE;
        endcase
      end
      if (step[ST_X3]) begin
        case (opc)
          OP_ADD: begin
            c.alu_drv = 1'b1;
            c.a_ld    = 1'b1;
          end
          OP_SUB: begin
            c.alu_drv = 1'b1;
            c.sub_sel = 1'b1;
            c.a_ld    = 1'b1;
          end
          default: c = CTRL_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic        clk,
  input  logic        clr,
  input  logic        ld_we,
  input  logic [3:0]  ld_addr,
  input  logic [7:0]  ld_data,
  output logic [7:0]  out_reg,
  output logic        halted
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] ir_q, a_q, b_q, out_q;
  logic              halt_q;
  logic [WORD_W-1:0] bus, mem_rd, alu_y;
  logic [NSTEPS-1:0] step;
  ctrl_t             c;

  // named events for the checks
  logic ev_pc_inc, ev_out_load, ev_halt, ev_ring_hold;
  assign ev_pc_inc    = c.pc_inc;
  assign ev_out_load  = c.out_ld;
  assign ev_halt      = c.halt_req;
  assign ev_ring_hold = halt_q | c.halt_req;

  acc_ring u_ring (
    .clk  (clk),
    .clr  (clr),
    .hold (ev_ring_hold),
    .step (step)
  );

  acc_ctrl u_ctrl (
    .step   (step),
    .opc    (ir_q[WORD_W-1:ADDR_W]),
    .halted (halt_q),
    .c      (c)
  );

  acc_mem u_mem (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (mar_q),
    .rdata (mem_rd)
  );

  assign alu_y = alu_calc(a_q, b_q, c.sub_sel);

  always_comb begin
    bus = '0;
    if (c.pc_drv)       bus = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
    else if (c.mem_drv) bus = mem_rd;
    else if (c.ir_drv)  bus = {{(WORD_W-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
    else if (c.a_drv)   bus = a_q;
    else if (c.alu_drv) bus = alu_y;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      pc_q   <= '0;
      mar_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      out_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      if (c.pc_inc)   pc_q   <= pc_q + 1'b1;
      if (c.mar_ld)   mar_q  <= bus[ADDR_W-1:0];
      if (c.ir_ld)    ir_q   <= bus;
      if (c.a_ld)     a_q    <= bus;
      if (c.b_ld)     b_q    <= bus;
      if (c.out_ld)   out_q  <= bus;
      if (c.halt_req) halt_q <= 1'b1;
    end
  end

  assign out_reg = out_q;
  assign halted  = halt_q;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (clr)
    $countones({c.pc_drv, c.mem_drv, c.ir_drv, c.a_drv, c.alu_drv}) <= 1); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (clr)
    halted |=> halted); // R8
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (clr)
    halted |=> $stable(pc_q)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (clr)
    !ev_out_load |=> $stable(out_reg)); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (clr)
    ev_pc_inc |=> pc_q == $past(pc_q) + 1'b1); // R3
  AST_HALT_RISE: assert property (@(posedge clk) disable iff (clr)
    $rose(halted) |-> $past(ev_halt)); // R8
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       ld_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] out_reg;
  logic       halted;

  int total = 0;
  int fails = 0;
  logic [7:0] img [16];

  acc_cpu uut (
    .clk(clk), .clr(clr), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .out_reg(out_reg), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // instruction-set model: final output and edge at which halt rises
  task automatic model_run(output logic [7:0] o, output int hedge);
    logic [3:0] pc = 4'd0;
    logic [7:0] acc = 8'd0;
    o = 8'd0;
    hedge = -1;
    for (int k = 0; k < 64; k++) begin
      logic [7:0] ins = img[pc];
      logic [7:0] m = img[ins[3:0]];
      pc = pc + 4'd1;
      case (ins[7:4])
        4'h0: acc = m;
        4'h1: acc = 8'((int'(acc) + int'(m)) % 256);
        4'h2: acc = 8'((int'(acc) - int'(m) + 256) % 256);
        4'h3: o = acc;
        4'hF: begin hedge = 6*k + 4; break; end
        default: ;
      endcase
    end
  endtask

  task automatic load_and_clear();
    clr = 1'b1;
    for (int i = 0; i < 16; i++) begin
      ld_we = 1'b1; ld_addr = 4'(i); ld_data = img[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_to_halt(output logic [7:0] o, output int edges);
    clr = 1'b0;
    edges = 0;
    while (!halted && edges < 400) begin
      @(posedge clk); @(negedge clk);
      edges++;
    end
    o = out_reg;
  endtask

  task automatic run_and_check(input string tag);
    logic [7:0] o, eo;
    int e, ee;
    model_run(eo, ee);
    load_and_clear();
    run_to_halt(o, e);
    chk({tag, " result"}, o, eo);
    chk("R3 halt edge", e, ee);
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 8'hFF;
  endtask

  task automatic ref_prog();
    clear_img();
    img[0] = 8'h09; img[1] = 8'h1A; img[2] = 8'h1B; img[3] = 8'h2C;
    img[4] = 8'h30; img[5] = 8'hF0;
    img[9] = 8'h01; img[10] = 8'h04; img[11] = 8'h02; img[12] = 8'h03;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] o;
    int e;
    @(negedge clk); @(negedge clk);
    // R10 reset state
    chk("R10 out after clear", out_reg, 0);
    chk("R10 halted after clear", halted, 0);

    // R12 reference program with step timing (R7, R3, R8)
    ref_prog();
    load_and_clear();
    clr = 1'b0;
    repeat (27) @(posedge clk);
    @(negedge clk);
    chk("R7 out before show step", out_reg, 0);
    @(posedge clk); @(negedge clk);
    chk("R12 out after show step", out_reg, 8'h04);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R3 halted not yet at edge 33", halted, 0);
    @(posedge clk); @(negedge clk);
    chk("R8 halted at edge 34", halted, 1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R8 halted stays", halted, 1);
    chk("R8 out frozen", out_reg, 8'h04);

    // R10 clear mid-run, restart from address 0
    load_and_clear();
    clr = 1'b0;
    repeat (29) @(posedge clk);
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 out cleared mid-run", out_reg, 0);
    chk("R10 halted cleared", halted, 0);
    run_to_halt(o, e);
    chk("R10 restart result", o, 8'h04);
    chk("R10 restart halt edge", e, 34);

    // R9 undefined codes are no-ops
    clear_img();
    img[0] = 8'h09; img[1] = 8'h4A; img[2] = 8'h7B; img[3] = 8'h30;
    img[4] = 8'hF0; img[9] = 8'h5A; img[10] = 8'h11; img[11] = 8'h22;
    run_and_check("R9 undefined codes");

    // R4 R7 load overwrites, several show steps, last wins
    clear_img();
    img[0] = 8'h0D; img[1] = 8'h30; img[2] = 8'h0E; img[3] = 8'h1E;
    img[4] = 8'h30; img[5] = 8'hF0; img[13] = 8'h33; img[14] = 8'h81;
    run_and_check("R4 R7 reload and show");

    // R6 underflow
    clear_img();
    img[0] = 8'h0E; img[1] = 8'h2F; img[2] = 8'h30; img[3] = 8'hF0;
    img[14] = 8'h01; img[15] = 8'h03;
    load_and_clear();
    run_to_halt(o, e);
    chk("R6 underflow 01-03", o, 8'hFE);

    // R1 R2 R5 R6 sweep over operand pairs
    for (int op = 1; op <= 2; op++) begin
      for (int a = 0; a < 256; a += 17) begin
        for (int b = 3; b < 256; b += 37) begin
          clear_img();
          img[0] = 8'h0E; img[1] = 8'((op << 4) | 4'hF);
          img[2] = 8'h30; img[3] = 8'hF0;
          img[14] = 8'(a); img[15] = 8'(b);
          load_and_clear();
          run_to_halt(o, e);
          if (op == 1) chk("R5 add wrap", o, (a + b) % 256);
          else         chk("R6 sub wrap", o, (a - b + 256) % 256);
          chk("R3 halt edge", e, 22);
        end
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule